// File: doc/BRIEF.md
# Range-Extended Hyperbolic CORDIC Exponential Unit

This block computes the natural exponential of a signed fixed-point argument. The argument is split into a whole-number part and a non-negative fraction. The whole-number part addresses a small table of precomputed powers of e. The fraction is fed to a hyperbolic CORDIC engine running in rotation mode. The engine uses only shifts, additions and a per-step arctanh constant. Multiplying the table entry by the engine's result yields exp of the full argument. This covers an input range that CORDIC alone could not handle with acceptable error.

A caller drives `start_i` with the argument while `ready_o` is high. After a fixed number of cycles the unit raises `done_o` for one cycle. At that point `result_o` carries the unsigned fixed-point exponential, and it keeps that value until the next result is written. Whole-number parts above the table range give the all-ones code. Whole-number parts below it give zero.

Top module: `hexp_unit`

## Requirements
- R1: While reset is held and in the first cycle after its release, `done_o` is 0, `ready_o` is 1 and `result_o` is 0.
- R2: For an argument whose whole part floor(A) is between 0 and INT_HI (4 by default), `result_o` read as an unsigned value with RES_FRAC (12) fraction bits is within 3 LSB plus 1.5e-4 of the true value of exp(A). The argument is a two's-complement number with ARG_FRAC (12) fraction bits.
- R3: For arguments whose whole part lies in [INT_LO, -1] (INT_LO is -4 by default), the result meets the same accuracy bound as R2.
- R4: For arguments with a zero whole part, the result is exp of the fraction, with the same accuracy bound, including fractions just below one.
- R5: When floor(A) is greater than INT_HI, `result_o` is all ones.
- R6: When floor(A) is less than INT_LO, `result_o` is zero.
- R7: `done_o` is high for exactly one cycle. It rises exactly 19 clock edges after the edge that accepted the start (16 CORDIC steps, one repeat each of steps 4 and 13, plus one product cycle).
- R8: `ready_o` is low from the accepting edge until the `done_o` cycle. A start raised while `ready_o` is low is ignored: it changes neither the result nor the timing of the operation in flight.
- R9: `result_o` changes only in the cycle in which `done_o` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request; accepted on an edge where `ready_o` is high |
| arg_i | input | ARG_W (16) | Signed argument, ARG_FRAC fraction bits |
| ready_o | output | 1 | High when a new request can be accepted |
| done_o | output | 1 | One-cycle pulse marking a fresh result |
| result_o | output | RES_W (24) | Unsigned exponential, RES_FRAC fraction bits |

## Verification
The bound checker watches the handshake and the result register on every cycle. It checks the one-cycle done pulse and the exact edge count from acceptance to done. It checks that ready stays low over the busy window and that the result holds outside done cycles. It also checks the saturated codes for arguments outside the table range. Numerical accuracy against the true exponential can only be shown by the bench's scenarios: directed points at the table edges, fraction-only arguments, and random arguments over positive and negative whole parts. The same holds for a start raised mid-operation leaving the in-flight result untouched.

// File: rtl/hexp_pkg.sv
package hexp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_MUL  = 2'd2
    } hexp_state_e;

    // iteration sequencer: current shift index and whether it is the second pass
    typedef struct packed {
        logic [5:0] idx;
        logic       again;
    } iter_ctl_t;

    // out-of-table flags for the whole-number part
    typedef struct packed {
        logic hi;
        logic lo;
    } clamp_t;

    // hyperbolic CORDIC needs steps 4, 13, 40, ... (k -> 3k+1) run twice
    function automatic bit is_double(input int j);
        int k = 4;
        bit hit = 1'b0;
        for (int n = 0; n < 6; n++) begin
            if (j == k) hit = 1'b1;
            k = 3 * k + 1;
        end
        return hit;
    endfunction

    function automatic int step_count(input int iters);
        int n = 0;
        for (int j = 1; j <= iters; j++) begin
            n = n + (is_double(j) ? 2 : 1);
        end
        return n;
    endfunction

    function automatic real pow2(input int e);
        real r = 1.0;
        for (int i = 0; i < e; i++) r = r * 2.0;
        return r;
    endfunction

    function automatic int atanh_fix(input int j, input int frac);
        real t = 1.0 / pow2(j);
        return $rtoi(0.5 * $ln((1.0 + t) / (1.0 - t)) * pow2(frac) + 0.5);
    endfunction

    // reciprocal of the hyperbolic gain over the full schedule
    function automatic int inv_gain_fix(input int iters, input int frac);
        real g = 1.0;
        for (int j = 1; j <= iters; j++) begin
            real f = $sqrt(1.0 - 1.0 / pow2(2 * j));
            g = g * f;
            if (is_double(j)) g = g * f;
        end
        return $rtoi(pow2(frac) / g + 0.5);
    endfunction

    function automatic int exp_fix(input int k, input int frac);
        return $rtoi($exp(real'(k)) * pow2(frac) + 0.5);
    endfunction

endpackage

// File: rtl/hexp_atanh_rom.sv
module hexp_atanh_rom
    import hexp_pkg::*;
#(
    parameter int CF    = 20,
    parameter int ITERS = 16,
    parameter int W     = CF + 3
) (
    input  logic [5:0]          idx_i,
    output logic signed [W-1:0] val_o
);

    logic signed [W-1:0] tbl [1:ITERS];

    for (genvar g = 1; g <= ITERS; g++) begin : g_ent
        assign tbl[g] = W'(atanh_fix(g, CF));
    end

    always_comb begin
        val_o = '0;
        for (int i = 1; i <= ITERS; i++) begin
            if (int'(idx_i) == i) val_o = tbl[i];
        end
    end

endmodule

// File: rtl/hexp_cordic.sv
module hexp_cordic
    import hexp_pkg::*;
#(
    parameter int FRAC_IN = 12,
    parameter int CF      = 20,
    parameter int ITERS   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [FRAC_IN-1:0] frac_i,
    output logic [CF+2:0]      exp_o,
    output logic               last_o
);

    localparam int W = CF + 3;
    localparam logic signed [W-1:0] X_INIT = W'(inv_gain_fix(ITERS, CF));

    logic signed [W-1:0] x_q, y_q, z_q;
    logic signed [W-1:0] x_d, y_d, z_d;
    logic signed [W-1:0] dx, dy, at_val, sum;
    iter_ctl_t           ctl_q, ctl_d;
    logic                dbl_now;
    logic                pos;

    hexp_atanh_rom #(.CF(CF), .ITERS(ITERS), .W(W)) u_atanh (
        .idx_i (ctl_q.idx),
        .val_o (at_val)
    );

    always_comb begin
        dbl_now = 1'b0;
        for (int i = 1; i <= ITERS; i++) begin
            if (int'(ctl_q.idx) == i && is_double(i)) dbl_now = 1'b1;
        end
    end

    assign pos = ~z_q[W-1];
    assign dx  = y_q >>> ctl_q.idx;
    assign dy  = x_q >>> ctl_q.idx;

    always_comb begin
        x_d   = x_q;
        y_d   = y_q;
        z_d   = z_q;
        ctl_d = ctl_q;
        if (load_i) begin
            x_d   = X_INIT;
            y_d   = '0;
            z_d   = W'(frac_i) << (CF - FRAC_IN);
            ctl_d = '{idx: 6'd1, again: 1'b0};
        end else if (step_i) begin
            x_d = pos ? x_q + dx : x_q - dx;
            y_d = pos ? y_q + dy : y_q - dy;
            z_d = pos ? z_q - at_val : z_q + at_val;
            if (dbl_now && !ctl_q.again) begin
                ctl_d.again = 1'b1;
            end else begin
                ctl_d.idx   = ctl_q.idx + 6'd1;
                ctl_d.again = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            y_q   <= '0;
            z_q   <= '0;
            ctl_q <= '{idx: 6'd1, again: 1'b0};
        end else begin
            x_q   <= x_d;
            y_q   <= y_d;
            z_q   <= z_d;
            ctl_q <= ctl_d;
        end
    end

    assign last_o = (ctl_q.idx == 6'(ITERS)) && !(dbl_now && !ctl_q.again);
    assign sum    = x_q + y_q;
    assign exp_o  = sum;

endmodule

// File: rtl/hexp_int_rom.sv
module hexp_int_rom
    import hexp_pkg::*;
#(
    parameter int IB       = 4,
    parameter int TBL_W    = 24,
    parameter int TBL_FRAC = 16,
    parameter int INT_LO   = -4,
    parameter int INT_HI   = 4
) (
    input  logic signed [IB-1:0] b_i,
    output logic [TBL_W-1:0]     val_o,
    output clamp_t               clamp_o
);

    localparam int NENT = INT_HI - INT_LO + 1;

    logic [TBL_W-1:0] rom [NENT];
    int               bi;

    for (genvar g = 0; g < NENT; g++) begin : g_pow
        assign rom[g] = TBL_W'(exp_fix(INT_LO + g, TBL_FRAC));
    end

    assign bi = int'(b_i);

    always_comb begin
        val_o = '0;
        for (int i = 0; i < NENT; i++) begin
            if (bi == INT_LO + i) val_o = rom[i];
        end
        clamp_o.hi = (bi > INT_HI);
        clamp_o.lo = (bi < INT_LO);
    end

endmodule

// File: rtl/hexp_scale.sv
module hexp_scale
    import hexp_pkg::*;
#(
    parameter int TBL_W    = 24,
    parameter int TBL_FRAC = 16,
    parameter int EW       = 23,
    parameter int CF       = 20,
    parameter int RES_W    = 24,
    parameter int RES_FRAC = 12
) (
    input  logic [TBL_W-1:0] tbl_i,
    input  logic [EW-1:0]    exp_i,
    input  clamp_t           clamp_i,
    output logic [RES_W-1:0] res_o
);

    localparam int PW = TBL_W + EW;
    localparam int SH = TBL_FRAC + CF - RES_FRAC;

    logic [PW-1:0] prod, rnd, shifted;

    assign prod    = PW'(tbl_i) * PW'(exp_i);
    assign rnd     = prod + (PW'(1) << (SH - 1));
    assign shifted = rnd >> SH;

    always_comb begin
        if (clamp_i.hi || (|shifted[PW-1:RES_W])) begin
            res_o = '1;
        end else if (clamp_i.lo) begin
            res_o = '0;
        end else begin
            res_o = shifted[RES_W-1:0];
        end
    end

endmodule

// File: rtl/hexp_unit.sv
module hexp_unit
    import hexp_pkg::*;
#(
    parameter int ARG_W       = 16,
    parameter int ARG_FRAC    = 12,
    parameter int RES_W       = 24,
    parameter int RES_FRAC    = 12,
    parameter int CORDIC_FRAC = 20,
    parameter int ITERS       = 16,
    parameter int INT_LO      = -4,
    parameter int INT_HI      = 4,
    parameter int TBL_FRAC    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [ARG_W-1:0] arg_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    localparam int IB    = ARG_W - ARG_FRAC;
    localparam int TBL_W = RES_W;
    localparam int EW    = CORDIC_FRAC + 3;

    hexp_state_e      state_q;
    logic [TBL_W-1:0] tbl_q, tbl_d;
    clamp_t           clamp_q, clamp_d;
    logic [EW-1:0]    ecx;
    logic [RES_W-1:0] res_q, res_d;
    logic             done_q;
    logic             accept, step, last;

    assign accept = start_i && (state_q == ST_IDLE);
    assign step   = (state_q == ST_ITER);

    hexp_int_rom #(
        .IB(IB), .TBL_W(TBL_W), .TBL_FRAC(TBL_FRAC),
        .INT_LO(INT_LO), .INT_HI(INT_HI)
    ) u_int (
        .b_i     ($signed(arg_i[ARG_W-1:ARG_FRAC])),
        .val_o   (tbl_d),
        .clamp_o (clamp_d)
    );

    hexp_cordic #(
        .FRAC_IN(ARG_FRAC), .CF(CORDIC_FRAC), .ITERS(ITERS)
    ) u_cordic (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .step_i (step),
        .frac_i (arg_i[ARG_FRAC-1:0]),
        .exp_o  (ecx),
        .last_o (last)
    );

    hexp_scale #(
        .TBL_W(TBL_W), .TBL_FRAC(TBL_FRAC), .EW(EW), .CF(CORDIC_FRAC),
        .RES_W(RES_W), .RES_FRAC(RES_FRAC)
    ) u_scale (
        .tbl_i   (tbl_q),
        .exp_i   (ecx),
        .clamp_i (clamp_q),
        .res_o   (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tbl_q   <= '0;
            clamp_q <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        tbl_q   <= tbl_d;
                        clamp_q <= clamp_d;
                        state_q <= ST_ITER;
                    end
                end
                ST_ITER: begin
                    if (last) state_q <= ST_MUL;
                end
                ST_MUL: begin
                    res_q   <= res_d;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready_o  = (state_q == ST_IDLE);
    assign done_o   = done_q;
    assign result_o = res_q;

endmodule

// File: rtl/hexp_unit_chk.sv
module hexp_unit_chk
    import hexp_pkg::*;
#(
    parameter int ARG_W    = 16,
    parameter int ARG_FRAC = 12,
    parameter int RES_W    = 24,
    parameter int ITERS    = 16,
    parameter int INT_LO   = -4,
    parameter int INT_HI   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [ARG_W-1:0] arg_i,
    input logic             ready_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o
);

    localparam int LAT = step_count(ITERS) + 1;

    logic busy;
    int   cnt;
    int   whole_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= 0;
            whole_q <= 0;
        end else if (start_i && ready_o) begin
            busy    <= 1'b1;
            cnt     <= 0;
            whole_q <= int'($signed(arg_i)) >>> ARG_FRAC;
        end else if (busy) begin
            if (done_o) busy <= 1'b0;
            cnt <= cnt + 1;
        end
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_done_on_time: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAT) |-> done_o);

    a_r7_no_stray_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy && cnt == LAT));

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt < LAT) |-> !ready_o);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    a_r5_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (done_o && whole_q > INT_HI) |-> (result_o == '1));

    a_r6_clamp_low: assert property (@(posedge clk) disable iff (rst)
        (done_o && whole_q < INT_LO) |-> (result_o == '0));

endmodule

bind hexp_unit hexp_unit_chk #(
    .ARG_W(ARG_W), .ARG_FRAC(ARG_FRAC), .RES_W(RES_W),
    .ITERS(ITERS), .INT_LO(INT_LO), .INT_HI(INT_HI)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .arg_i    (arg_i),
    .ready_o  (ready_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/hexp_unit_test.sv
module hexp_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 19;   // 16 steps + repeats of 4 and 13 + product
    localparam int INT_LO     = -4;
    localparam int INT_HI     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] arg = '0;
    logic        ready, done;
    logic [23:0] result;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hexp_unit uut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .arg_i    (arg),
        .ready_o  (ready),
        .done_o   (done),
        .result_o (result)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
        end
    endtask

    task automatic check_value(input logic [15:0] a, input string req);
        int  whole = int'($signed(a)) >>> 12;
        real act   = real'(result);
        if (whole > INT_HI) begin
            check(result == 24'hFFFFFF, req, "high clamp", act, 16777215.0);
        end else if (whole < INT_LO) begin
            check(result == 24'h0, req, "low clamp", act, 0.0);
        end else begin
            real exp  = $exp(real'($signed(a)) / 4096.0) * 4096.0;
            real diff = act - exp;
            if (diff < 0.0) diff = -diff;
            check(diff <= 3.0 + exp * 1.5e-4, req, "exp value", act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] a, input string req,
                          input bit poke, input logic [15:0] other);
        int k = 0;
        logic [23:0] hold;
        @(negedge clk);
        arg   = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        arg   = ~a;
        check(!ready, "R8", "ready after accept", real'(ready), 0.0);
        while (!done && k < LAT + 4) begin
            start = poke && (k == 3);
            arg   = start ? other : ~a;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check(k == LAT, "R7", "latency", real'(k), real'(LAT));
        check(ready, "R8", "ready at done", real'(ready), 1.0);
        check_value(a, req);
        hold = result;
        @(negedge clk);
        check(!done, "R7", "done width", real'(done), 0.0);
        repeat (3) @(negedge clk);
        check(result == hold, "R9", "result hold", real'(result), real'(hold));
    endtask

    task automatic run_all();
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(!done && ready && result == 0, "R1", "in reset", real'(result), 0.0);
        rst = 1'b0;
        @(negedge clk);
        check(!done, "R1", "done after reset", real'(done), 0.0);
        check(ready, "R1", "ready after reset", real'(ready), 1.0);
        check(result == 0, "R1", "result after reset", real'(result), 0.0);

        run_op(16'h1000, "R2", 1'b0, 16'h0);   // e
        run_op(16'h4FFF, "R2", 1'b0, 16'h0);   // top of table range
        run_op(16'h4000, "R2", 1'b0, 16'h0);
        run_op(16'hF000, "R3", 1'b0, 16'h0);   // -1
        run_op(16'hC000, "R3", 1'b0, 16'h0);   // bottom of table range
        run_op(16'hC001, "R3", 1'b0, 16'h0);
        run_op(16'h0000, "R4", 1'b0, 16'h0);   // exp(0) = 1
        run_op(16'h0800, "R4", 1'b0, 16'h0);
        run_op(16'h0FFF, "R4", 1'b0, 16'h0);
        run_op(16'h5000, "R5", 1'b0, 16'h0);
        run_op(16'h7FFF, "R5", 1'b0, 16'h0);
        run_op(16'hBFFF, "R6", 1'b0, 16'h0);
        run_op(16'h8000, "R6", 1'b0, 16'h0);
        // start while busy must be ignored (R8)
        run_op(16'h2345, "R8", 1'b1, 16'h7000);
        run_op(16'hD800, "R8", 1'b1, 16'h0100);

        for (int n = 0; n < 40; n++) begin
            int          w = int'($urandom_range(8)) - 4;
            int unsigned f = $urandom_range(4095);
            logic [15:0] a = {4'(w), 12'(f)};
            run_op(a, (w >= 0) ? "R2" : "R3", 1'b0, 16'h0);
        end
        for (int n = 0; n < 12; n++) begin
            logic [15:0] a = 16'($urandom());
            int whole = int'($signed(a)) >>> 12;
            run_op(a, (whole > INT_HI) ? "R5" : (whole < INT_LO) ? "R6" : "R2", 1'b0, 16'h0);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule